// File: doc/BRIEF.md
# Fetch Redirect and Taken-Branch Prediction Unit

This block selects the fetch address for a five-stage in-order pipeline (fetch, decode, execute, memory, writeback). A predicted-PC register drives the fetch address in the normal case. Every jump is assumed taken, so the next prediction after a fetched jump is the jump's encoded target. After any other instruction, the next prediction is its fall-through address. When a halt is fetched, the prediction is set back to the current fetch address, so the halt stays in fetch. This hold does not stall the prediction register.

The block keeps its own short record of each conditional jump as it moves through decode, execute and memory. The record holds the jump's fall-through address and, once the jump leaves execute, its condition result. A conditional jump whose condition fails in execute is a misprediction. In that cycle the unit raises bubble on the decode and execute pipeline registers, which squashes the two wrong-path instructions. In the next cycle, while the jump sits in memory, the unit fetches from the saved fall-through address. The surrounding pipeline supplies the opcode and function fields, the fall-through and target addresses of the fetched instruction, and the execute-stage condition result.

Top module: `fetch_redirect`

## Requirements
- R1: While rst_ni is low, pc_o is 0 and both bubble_d_o and bubble_e_o are high. The first fetch after reset release is at address 0.
- R2: If no bubble was raised in the previous cycle, pc_o equals the value pred_pc_o had in that cycle.
- R3: A fetched jump (icode 7, any ifun) gives pred_pc_o = valc_i.
- R4: A fetched halt (icode 0) gives pred_pc_o = pc_o, so the same address is fetched again.
- R5: Any other fetched opcode gives pred_pc_o = valp_i.
- R6: bubble_d_o and bubble_e_o are high together, and only in the cycle in which a conditional jump (icode 7, ifun not 0) fetched two cycles earlier, and not squashed, is in execute with e_cond_i low.
- R7: In the cycle after a bubble, pc_o equals the fall-through address (valp_i) of the jump that caused it.
- R8: An unconditional jump (icode 7, ifun 0) never raises a bubble or a redirect, whatever e_cond_i is.
- R9: e_cond_i has no effect when execute does not hold a conditional jump.
- R10: Instructions squashed by a bubble have no later effect. A conditional jump among them never causes a bubble or redirect.
- R11: A conditional jump that is not taken costs exactly two wrong-path fetches. The fall-through address is fetched three cycles after the jump.
- R12: A halt fetched through a redirect stays at the same fetch address in the following cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| icode_i | input | 4 | Opcode of the instruction fetched at pc_o |
| ifun_i | input | 4 | Function field of the fetched instruction; 0 marks an unconditional jump |
| valp_i | input | 64 | Fall-through address of the fetched instruction |
| valc_i | input | 64 | Encoded target of the fetched instruction |
| e_cond_i | input | 1 | Condition result of the instruction in execute |
| pc_o | output | 64 | Current fetch address |
| pred_pc_o | output | 64 | Next predicted PC, loaded into the prediction register |
| bubble_d_o | output | 1 | Squash request for the decode pipeline register |
| bubble_e_o | output | 1 | Squash request for the execute pipeline register |

## Verification
The bound checker checks the per-cycle relations at the ports on every cycle. These are: fetch following the previous prediction, the prediction choice by opcode, the two bubbles rising together and only two cycles after a conditional jump was fetched, the redirect to that jump's fall-through address, and the silence after unconditional jumps. The bench's reference model and directed programs cover what needs a whole program to show. That includes the exact two-slot penalty, the halt that stays in fetch after a redirect, wrong-path jumps that must stay inert, and a condition input that is ignored when execute holds no conditional jump.

// File: rtl/fetch_redirect_pkg.sv
package fetch_redirect_pkg;
  localparam int unsigned OP_W = 4;
  localparam logic [OP_W-1:0] OP_HALT = 4'h0;
  localparam logic [OP_W-1:0] OP_NOP  = 4'h1;
  localparam logic [OP_W-1:0] OP_JUMP = 4'h7;
  localparam logic [OP_W-1:0] FN_ALWAYS = 4'h0;

  typedef enum logic [1:0] {
    NXT_FALL = 2'd0,
    NXT_TGT  = 2'd1,
    NXT_HOLD = 2'd2
  } nxt_sel_e;

  typedef struct packed {
    logic is_jump;
    logic is_cond;
    logic is_halt;
  } op_class_t;
endpackage

// File: rtl/fr_classify.sv
module fr_classify
  import fetch_redirect_pkg::*;
(
  input  logic [OP_W-1:0] icode_i,
  input  logic [OP_W-1:0] ifun_i,
  output op_class_t       cls_o,
  output nxt_sel_e        sel_o
);
  always_comb begin
    cls_o.is_jump = (icode_i == OP_JUMP);
    cls_o.is_cond = (icode_i == OP_JUMP) && (ifun_i != FN_ALWAYS);
    cls_o.is_halt = (icode_i == OP_HALT);
    if (cls_o.is_halt)      sel_o = NXT_HOLD;
    else if (cls_o.is_jump) sel_o = NXT_TGT;
    else                    sel_o = NXT_FALL;
  end
endmodule

// File: rtl/fr_track.sv
module fr_track #(
  parameter int unsigned PC_W  = 64,
  parameter int unsigned N_STG = 3,
  parameter int unsigned N_BUB = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            f_jcc_i,
  input  logic [PC_W-1:0] f_fall_i,
  input  logic            e_cond_i,
  output logic            squash_o,
  output logic            redirect_o,
  output logic [PC_W-1:0] redirect_pc_o
);
  localparam int unsigned E_IDX = N_STG - 2;
  localparam int unsigned M_IDX = N_STG - 1;

  logic [N_STG-1:0] jcc_q;
  logic [PC_W-1:0]  fall_q [N_STG];
  logic             m_cond_q;

  // a conditional jump failing its test in execute
  assign squash_o = jcc_q[E_IDX] && !e_cond_i;

  for (genvar g = 0; g < N_STG; g++) begin : g_stg
    logic            jcc_in;
    logic [PC_W-1:0] fall_in;
    if (g == 0) begin : g_src_f
      assign jcc_in  = f_jcc_i;
      assign fall_in = f_fall_i;
    end else begin : g_src_prev
      assign jcc_in  = jcc_q[g-1];
      assign fall_in = fall_q[g-1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        jcc_q[g]  <= 1'b0;
        fall_q[g] <= '0;
      end else if ((g < N_BUB) && squash_o) begin
        jcc_q[g]  <= 1'b0;
        fall_q[g] <= '0;
      end else begin
        jcc_q[g]  <= jcc_in;
        fall_q[g] <= fall_in;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) m_cond_q <= 1'b0;
    else         m_cond_q <= e_cond_i;
  end

  assign redirect_o    = jcc_q[M_IDX] && !m_cond_q;
  assign redirect_pc_o = fall_q[M_IDX];
endmodule

// File: rtl/fr_pc_sel.sv
module fr_pc_sel
  import fetch_redirect_pkg::*;
#(
  parameter int unsigned PC_W = 64
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  nxt_sel_e        sel_i,
  input  logic [PC_W-1:0] valp_i,
  input  logic [PC_W-1:0] valc_i,
  input  logic            redirect_i,
  input  logic [PC_W-1:0] redirect_pc_i,
  output logic [PC_W-1:0] pc_o,
  output logic [PC_W-1:0] pred_next_o
);
  logic [PC_W-1:0] pred_q;

  assign pc_o = redirect_i ? redirect_pc_i : pred_q;

  // halt holds by re-predicting its own address
  always_comb begin
    unique case (sel_i)
      NXT_HOLD: pred_next_o = pc_o;
      NXT_TGT:  pred_next_o = valc_i;
      default:  pred_next_o = valp_i;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pred_q <= '0;
    else         pred_q <= pred_next_o;
  end
endmodule

// File: rtl/fetch_redirect.sv
module fetch_redirect
  import fetch_redirect_pkg::*;
#(
  parameter int unsigned PC_W = 64
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [3:0]      icode_i,
  input  logic [3:0]      ifun_i,
  input  logic [PC_W-1:0] valp_i,
  input  logic [PC_W-1:0] valc_i,
  input  logic            e_cond_i,
  output logic [PC_W-1:0] pc_o,
  output logic [PC_W-1:0] pred_pc_o,
  output logic            bubble_d_o,
  output logic            bubble_e_o
);
  op_class_t       cls;
  nxt_sel_e        sel;
  logic            squash;
  logic            redirect;
  logic [PC_W-1:0] redirect_pc;

  fr_classify u_cls (
    .icode_i (icode_i),
    .ifun_i  (ifun_i),
    .cls_o   (cls),
    .sel_o   (sel)
  );

  fr_track #(.PC_W(PC_W), .N_STG(3), .N_BUB(2)) u_trk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .f_jcc_i       (cls.is_cond),
    .f_fall_i      (valp_i),
    .e_cond_i      (e_cond_i),
    .squash_o      (squash),
    .redirect_o    (redirect),
    .redirect_pc_o (redirect_pc)
  );

  fr_pc_sel #(.PC_W(PC_W)) u_pc (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .sel_i         (sel),
    .valp_i        (valp_i),
    .valc_i        (valc_i),
    .redirect_i    (redirect),
    .redirect_pc_i (redirect_pc),
    .pc_o          (pc_o),
    .pred_next_o   (pred_pc_o)
  );

  assign bubble_d_o = squash || !rst_ni;
  assign bubble_e_o = squash || !rst_ni;

  logic unused_cls;
  assign unused_cls = cls.is_jump ^ cls.is_halt;
endmodule

// File: rtl/fetch_redirect_chk.sv
module fetch_redirect_chk #(
  parameter int unsigned PC_W = 64
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [3:0]      icode_i,
  input logic [3:0]      ifun_i,
  input logic [PC_W-1:0] valp_i,
  input logic [PC_W-1:0] valc_i,
  input logic [PC_W-1:0] pc_o,
  input logic [PC_W-1:0] pred_pc_o,
  input logic            bubble_d_o,
  input logic            bubble_e_o
);
  logic f_jump, f_cond, f_uncond;
  assign f_jump   = (icode_i == 4'h7);
  assign f_cond   = f_jump && (ifun_i != 4'h0);
  assign f_uncond = f_jump && (ifun_i == 4'h0);

  a_r2_follow_pred: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bubble_e_o |=> pc_o == $past(pred_pc_o));
  a_r3_jump_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
    f_jump |-> pred_pc_o == valc_i);
  a_r4_halt_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (icode_i == 4'h0) |-> pred_pc_o == pc_o);
  a_r5_fall_thru: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!f_jump && icode_i != 4'h0) |-> pred_pc_o == valp_i);
  a_r6_bubble_pair: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bubble_d_o == bubble_e_o);
  a_r6_bubble_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bubble_e_o |-> $past(f_cond, 2));
  a_r7_redirect_pc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bubble_e_o |=> pc_o == $past(valp_i, 3));
  a_r8_uncond_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(f_uncond, 2) |-> !bubble_e_o);
endmodule

bind fetch_redirect fetch_redirect_chk #(.PC_W(PC_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .icode_i    (icode_i),
  .ifun_i     (ifun_i),
  .valp_i     (valp_i),
  .valc_i     (valc_i),
  .pc_o       (pc_o),
  .pred_pc_o  (pred_pc_o),
  .bubble_d_o (bubble_d_o),
  .bubble_e_o (bubble_e_o)
);

// File: tb/sim_fetch_redirect.sv
`timescale 1ns/1ps
module sim_fetch_redirect;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  icode_i = 4'h1;
  logic [3:0]  ifun_i = 4'h0;
  logic [63:0] valp_i = '0;
  logic [63:0] valc_i = '0;
  logic        e_cond_i = 1'b0;
  logic [63:0] pc_o, pred_pc_o;
  logic        bubble_d_o, bubble_e_o;

  always #2 clk_i = ~clk_i;

  fetch_redirect u0 (.*);

  int checks = 0;
  int fails  = 0;
  int prog   = 0;   // 0: directed not-taken, 1: directed taken, 2: random
  int unsigned seed_mix = 0;
  bit done = 1'b0;

  // bench model
  logic [63:0] m_pred;
  logic d_j, e_j, m_j, m_c, d_c, e_c;
  logic [63:0] d_f, e_f, m_f;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // instruction at an address: {icode, ifun, len, target}
  function automatic void decode(input logic [63:0] a, output logic [3:0] ic,
                                 output logic [3:0] fn, output logic [63:0] tg, output int len);
    int unsigned h;
    h = (a[31:0] * 32'h9E3779B1) ^ seed_mix;
    h = h ^ (h >> 13);
    ic = 4'h1; fn = 4'h0; tg = 64'(h[23:16]); len = 1;
    if (prog < 2) begin
      if (a == 64'h0) begin ic = 4'h7; fn = 4'h2; tg = 64'h40; len = 9; end
      else if (a == 64'h9) ic = 4'h0;
    end else begin
      case (h % 8)
        3, 4: begin ic = 4'h7; fn = 4'(1 + h[27:26]); len = 9; end
        5:    begin ic = 4'h7; fn = 4'h0; len = 9; end
        6:    begin ic = 4'h6; fn = 4'(h[31:28]); len = 2; end
        7:    begin ic = 4'h3; len = 10; end
        default: ;
      endcase
    end
  endfunction

  task automatic model_reset();
    m_pred = '0;
    d_j = 0; e_j = 0; m_j = 0; m_c = 0; d_c = 0; e_c = 0;
    d_f = '0; e_f = '0; m_f = '0;
  endtask

  // one cycle, called just after a falling edge
  task automatic step();
    logic [3:0] ic, fn; logic [63:0] tg, exp_pc, exp_pred; int len;
    logic cnd, sq;
    exp_pc = (m_j && !m_c) ? m_f : m_pred;
    chk(pc_o == exp_pc, (m_j && !m_c) ? "R7 redirect fetch" : "R2 predicted fetch", pc_o, exp_pc);
    decode(pc_o, ic, fn, tg, len);
    icode_i = ic; ifun_i = fn; valc_i = tg; valp_i = pc_o + 64'(len);
    cnd = (prog == 0) ? 1'b0 : (prog == 1) ? 1'b1 : 1'($urandom % 2);
    // R9: random condition when execute holds no conditional jump
    e_cond_i = e_j ? e_c : 1'($urandom % 2);
    #0.5;
    if (ic == 4'h0) exp_pred = pc_o;
    else if (ic == 4'h7) exp_pred = tg;
    else exp_pred = valp_i;
    chk(pred_pc_o == exp_pred, (ic == 4'h0) ? "R4 halt hold" : (ic == 4'h7) ? "R3 taken prediction" : "R5 fall-through",
        pred_pc_o, exp_pred);
    sq = e_j && !e_c;
    chk(bubble_d_o == sq && bubble_e_o == sq, "R6 R8 R9 R10 bubble", {62'b0, bubble_d_o, bubble_e_o}, {62'b0, sq, sq});
    m_pred = exp_pred;
    m_j = e_j; m_c = e_cond_i; m_f = e_f;
    e_j = sq ? 1'b0 : d_j; e_c = d_c; e_f = sq ? '0 : d_f;
    d_j = sq ? 1'b0 : (ic == 4'h7 && fn != 4'h0); d_c = cnd; d_f = sq ? '0 : valp_i;
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    icode_i = 4'h1; ifun_i = 4'h0;
    model_reset();
    repeat (2) @(negedge clk_i);
    chk(pc_o == 64'h0, "R1 reset pc", pc_o, 64'h0);
    chk(bubble_d_o && bubble_e_o, "R1 reset bubbles", {62'b0, bubble_d_o, bubble_e_o}, 64'h3);
    rst_ni = 1'b1;
  endtask

  initial begin
    logic [63:0] seen [6];
    void'($urandom(32'd2024));
    // directed: not-taken jump at 0, halt at fall-through 9
    prog = 0; do_reset();
    for (int i = 0; i < 6; i++) begin
      seen[i] = pc_o; step(); @(negedge clk_i);
    end
    chk(seen[0] == 64'h0,  "R1 first fetch", seen[0], 64'h0);
    chk(seen[1] == 64'h40 && seen[2] == 64'h41, "R11 two wrong-path fetches", seen[2], 64'h41);
    chk(seen[3] == 64'h9,  "R11 fall-through on third cycle", seen[3], 64'h9);
    chk(seen[4] == 64'h9 && seen[5] == 64'h9, "R12 halt held after redirect", seen[5], 64'h9);
    // directed: same jump taken, no redirect
    prog = 1; do_reset();
    for (int i = 0; i < 6; i++) begin
      seen[i] = pc_o; step(); @(negedge clk_i);
    end
    chk(seen[3] == 64'h42 && seen[5] == 64'h44, "R6 taken jump no redirect", seen[3], 64'h42);
    // random programs
    prog = 2;
    for (int r = 0; r < 8; r++) begin
      seed_mix = $urandom;
      do_reset();
      for (int i = 0; i < 1500; i++) begin
        step(); @(negedge clk_i);
      end
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=0", checks);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule